// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Condition Flags

This block is the execute stage of a small 32-bit processor. It takes two operands, one from the register file and one that is either a second register or an immediate, together with a five-bit operation code. It returns the operation's result as a combinational value and a write-back enable that tells the register file whether the result is to be stored. It also keeps a six-bit condition register that later branch logic tests.

The operation set covers add, subtract, low-word multiply, compare, the three bitwise logic functions, shifts by one bit and by one byte in either direction, rotates by one bit, an arithmetic right shift by one, and a full byte-order reversal. The caller selects between a register operand and an immediate operand before this block, so each operation serves both forms. Compare computes the difference only to set the flags and never asks for a write-back.

The condition register loads at a rising clock edge when the flag write-enable is high and the code is defined. Otherwise it holds its value. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `alu_ccr`

## Requirements
- R1: Codes 0 (add), 1 (subtract, `opa - opb`, so 7 and 4 give 3) and 2 (multiply, low 32 bits of the product) drive `result` and raise `wb_en`.
- R2: Codes 4 (OR), 5 (AND) and 6 (XOR) drive the bitwise function of the operands on `result` and raise `wb_en`.
- R3: Codes 7 and 8 shift `opa` left by 1 and by 8 bits. Codes 9 and 10 shift it right by 1 and by 8 bits, filling with zeros. Code 13 shifts it right by 1 and copies bit 31 into the top bit. All of these raise `wb_en`.
- R4: Code 11 rotates `opa` left by one bit and code 12 rotates it right by one bit. Both raise `wb_en`.
- R5: Code 14 reverses the byte order of `opa`: bits 31..24 go to 7..0, 23..16 go to 15..8, 15..8 go to 23..16, and 7..0 go to 31..24. It raises `wb_en`.
- R6: Code 3 (compare) keeps `wb_en` low and still updates the flags as a subtraction of `opb` from `opa` would.
- R7: After an update, `flags` bit 0 is set when the result is zero, bit 2 when the operands are equal, bit 3 when they differ, bit 4 when `opa < opb` as signed values, and bit 5 when `opa > opb` as signed values.
- R8: Carry is `flags` bit 1. Add loads the carry out of bit 31. Subtract and compare load the borrow (`opa < opb` unsigned). Shifts and rotates load the last bit moved out: bit 31 for left-by-1 and rotate-left, bit 24 for left-by-8, bit 0 for right-by-1, rotate-right and the arithmetic shift, and bit 7 for right-by-8. Multiply, logic operations and byte reversal clear the carry.
- R9: While `flag_we` is low, `flags` keeps its value whatever the operands and code are.
- R10: Codes 15 to 31 are undefined. They drive `result` to zero, keep `wb_en` low and leave `flags` unchanged even when `flag_we` is high.
- R11: While reset is applied, and until it has been released, `flags` reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | 32 | First operand (register) |
| opb | input | 32 | Second operand (register or immediate) |
| op_sel | input | 5 | Operation code |
| flag_we | input | 1 | Condition register load enable |
| result | output | 32 | Combinational result |
| wb_en | output | 1 | Result is to be written back |
| flags | output | 6 | Condition register {gt, lt, ne, eq, carry, zero} |

## Verification
Every code, including the undefined ones, is swept over a grid of operands that contains zero, all-ones, the two signed extremes and mixed patterns. This exposes a sign fill missing from the arithmetic shift, a carry taken from the wrong end of a shift, an unsigned compare used where a signed one is required, and a byte reversal that swaps only halves.

Compare is checked for a stray write-back. Undefined codes are checked for disturbing the flags. Each value with `flag_we` high is followed by a cycle with `flag_we` low and different operands, so a condition register that loads without its enable shows a changed value.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_MUL   = 5'd2,
    OP_CMP   = 5'd3,
    OP_OR    = 5'd4,
    OP_AND   = 5'd5,
    OP_XOR   = 5'd6,
    OP_SHL1  = 5'd7,
    OP_SHL8  = 5'd8,
    OP_SHR1  = 5'd9,
    OP_SHR8  = 5'd10,
    OP_ROL1  = 5'd11,
    OP_ROR1  = 5'd12,
    OP_ASR1  = 5'd13,
    OP_BSWAP = 5'd14
  } alu_op_e;

  localparam int OP_W    = 5;
  localparam int BYTE_W  = 8;
  localparam int FLAG_W  = 6;

  // Packed MSB first: gt is bit 5, zero is bit 0.
  typedef struct packed {
    logic gt;
    logic lt;
    logic ne;
    logic eq;
    logic cy;
    logic z;
  } ccr_t;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_ccr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [OP_W-1:0] op,
  output logic [W-1:0]    res,
  output logic            cy,
  output logic            wr,
  output logic            valid
);
  localparam int NBYTES = W / BYTE_W;

  logic [W:0]   sum_ext;
  logic [W:0]   dif_ext;
  logic [W-1:0] prod;
  logic [W-1:0] swapped;

  assign sum_ext = {1'b0, a} + {1'b0, b};
  assign dif_ext = {1'b0, a} - {1'b0, b};
  assign prod    = a * b;

  for (genvar i = 0; i < NBYTES; i++) begin : g_swap
    assign swapped[i*BYTE_W +: BYTE_W] = a[(NBYTES-1-i)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    res   = '0;
    cy    = 1'b0;
    wr    = 1'b1;
    valid = 1'b1;
    case (op)
      OP_ADD:   begin res = sum_ext[W-1:0]; cy = sum_ext[W]; end
      OP_SUB:   begin res = dif_ext[W-1:0]; cy = dif_ext[W]; end
      OP_CMP:   begin res = dif_ext[W-1:0]; cy = dif_ext[W]; wr = 1'b0; end
      OP_MUL:   res = prod;
      OP_OR:    res = a | b;
      OP_AND:   res = a & b;
      OP_XOR:   res = a ^ b;
      OP_SHL1:  begin res = {a[W-2:0], 1'b0}; cy = a[W-1]; end
      OP_SHL8:  begin res = {a[W-BYTE_W-1:0], {BYTE_W{1'b0}}}; cy = a[W-BYTE_W]; end
      OP_SHR1:  begin res = {1'b0, a[W-1:1]}; cy = a[0]; end
      OP_SHR8:  begin res = {{BYTE_W{1'b0}}, a[W-1:BYTE_W]}; cy = a[BYTE_W-1]; end
      OP_ROL1:  begin res = {a[W-2:0], a[W-1]}; cy = a[W-1]; end
      OP_ROR1:  begin res = {a[0], a[W-1:1]}; cy = a[0]; end
      OP_ASR1:  begin res = {a[W-1], a[W-1:1]}; cy = a[0]; end
      OP_BSWAP: res = swapped;
      default:  begin wr = 1'b0; valid = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_ccr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] res,
  input  logic         cy,
  output ccr_t         ccr
);
  always_comb begin
    ccr.z  = (res == '0);
    ccr.cy = cy;
    ccr.eq = (a == b);
    ccr.ne = (a != b);
    ccr.lt = ($signed(a) < $signed(b));
    ccr.gt = ($signed(a) > $signed(b));
  end
endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
  import alu_ccr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [OP_W-1:0]  op_sel,
  input  logic             flag_we,
  output logic [W-1:0]     result,
  output logic             wb_en,
  output logic [FLAG_W-1:0] flags
);
  logic [1:0] rst_pipe;
  logic       rst_n_sync;
  logic       carry;
  logic       op_valid;
  logic       ccr_load;
  ccr_t       ccr_new;
  ccr_t       ccr_d;
  ccr_t       ccr_q;

  // Reset synchronizer: asserts at once, releases after two edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  alu_datapath #(.W(W)) u_dp (
    .a     (opa),
    .b     (opb),
    .op    (op_sel),
    .res   (result),
    .cy    (carry),
    .wr    (wb_en),
    .valid (op_valid)
  );

  alu_flag_gen #(.W(W)) u_fg (
    .a   (opa),
    .b   (opb),
    .res (result),
    .cy  (carry),
    .ccr (ccr_new)
  );

  assign ccr_load = flag_we & op_valid;

  always_comb begin
    ccr_d = ccr_q;
    if (ccr_load) ccr_d = ccr_new;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) ccr_q <= '0;
    else             ccr_q <= ccr_d;
  end

  assign flags = ccr_q;
endmodule

// File: rtl/alu_ccr_chk.sv
module alu_ccr_chk
  import alu_ccr_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_q,
  input logic [W-1:0]      opa,
  input logic [W-1:0]      opb,
  input logic [OP_W-1:0]   op_sel,
  input logic              flag_we,
  input logic [W-1:0]      result,
  input logic              wb_en,
  input logic [FLAG_W-1:0] flags
);
  logic defined;
  assign defined = (op_sel <= OP_BSWAP);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !flag_we |=> $stable(flags));

  assert_undef_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !defined |=> $stable(flags));

  assert_undef_nowb_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !defined |-> (!wb_en && result == '0));

  assert_cmp_nowb_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (op_sel == OP_CMP) |-> !wb_en);

  assert_eq_ne_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (flag_we && defined) |=> (flags[2] != flags[3]));

  assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (flag_we && defined) |=> (flags[0] == ($past(result) == '0)));

  assert_lt_gt_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !(flags[4] && flags[5]));

  assert_asr_sign_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (op_sel == OP_ASR1) |-> (result[W-1] == opa[W-1]));

  assert_reset_R11: assert property (@(posedge clk)
    !rst_q |-> (flags == '0));
endmodule

bind alu_ccr alu_ccr_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_q   (rst_n_sync),
  .opa     (opa),
  .opb     (opb),
  .op_sel  (op_sel),
  .flag_we (flag_we),
  .result  (result),
  .wb_en   (wb_en),
  .flags   (flags)
);

// File: tb/sim_alu_ccr.sv
`timescale 1ns/1ps
module sim_alu_ccr;
  logic        clk;
  logic        rst_n;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [4:0]  op_sel;
  logic        flag_we;
  logic [31:0] result;
  logic        wb_en;
  logic [5:0]  flags;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [5:0] model_flags;

  alu_ccr u0 (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op_sel(op_sel),
    .flag_we(flag_we), .result(result), .wb_en(wb_en), .flags(flags)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic string tag_of(input int op);
    case (op)
      0, 1, 2:            return "R1";
      3:                  return "R6";
      4, 5, 6:            return "R2";
      7, 8, 9, 10, 13:    return "R3";
      11, 12:             return "R4";
      14:                 return "R5";
      default:            return "R10";
    endcase
  endfunction

  task automatic expect_val(input string tag, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic c,
                       output logic w, output logic v);
    logic [63:0] p;
    longint unsigned s;
    r = 32'h0; c = 1'b0; w = 1'b1; v = 1'b1;
    case (op)
      0: begin s = longint'(a) + longint'(b); r = s[31:0]; c = s[32]; end
      1: begin r = a - b; c = (a < b); end
      2: begin p = {32'h0, a} * {32'h0, b}; r = p[31:0]; end
      3: begin r = a - b; c = (a < b); w = 1'b0; end
      4: r = a | b;
      5: r = a & b;
      6: r = a ^ b;
      7: begin r = a * 2; c = a[31]; end
      8: begin r = a * 256; c = a[24]; end
      9: begin r = a / 2; c = a[0]; end
      10: begin r = a / 256; c = a[7]; end
      11: begin r = (a << 1) | (a >> 31); c = a[31]; end
      12: begin r = (a >> 1) | (a << 31); c = a[0]; end
      13: begin r = (a >> 1) | (a[31] ? 32'h8000_0000 : 32'h0); c = a[0]; end
      14: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
      default: begin w = 1'b0; v = 1'b0; end
    endcase
  endtask

  // Drive at negedge, check comb outputs, clock flags in, check flags,
  // then one cycle with flag_we low and scrambled operands (R9).
  task automatic run_case(input int op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic c, w, v;
    string tg;
    tg = tag_of(op);
    model(op, a, b, r, c, w, v);
    opa = a; opb = b; op_sel = 5'(op); flag_we = 1'b1;
    #1;
    expect_val(tg, "result", {32'h0, result}, {32'h0, r});
    expect_val(tg, "wb_en", {63'h0, wb_en}, {63'h0, w});
    if (v)
      model_flags = {($signed(a) > $signed(b)), ($signed(a) < $signed(b)),
                     (a != b), (a == b), c, (r == 32'h0)};
    @(negedge clk);
    expect_val(v ? "R7/R8" : "R10", "flags", {58'h0, flags}, {58'h0, model_flags});
    opa = ~a; opb = a ^ 32'h5A5A_0F0F; op_sel = 5'(op ^ 1); flag_we = 1'b0;
    @(negedge clk);
    expect_val("R9", "flags held", {58'h0, flags}, {58'h0, model_flags});
  endtask

  logic [31:0] pat [12];

  initial begin
    pat[0]  = 32'h0000_0000; pat[1]  = 32'h0000_0001; pat[2]  = 32'h0000_0007;
    pat[3]  = 32'h0000_0004; pat[4]  = 32'hFFFF_FFFF; pat[5]  = 32'h8000_0000;
    pat[6]  = 32'h7FFF_FFFF; pat[7]  = 32'h1234_5678; pat[8]  = 32'hA5A5_A5A5;
    pat[9]  = 32'h0000_0100; pat[10] = 32'hFF00_FF01; pat[11] = 32'hDEAD_BEEF;
    rst_n = 1'b0; opa = '0; opb = '0; op_sel = '0; flag_we = 1'b0;
    model_flags = '0;
    // Reset state with flag_we high and an update-worthy input (R11).
    @(negedge clk);
    opa = 32'd5; opb = 32'd9; flag_we = 1'b1;
    @(negedge clk);
    expect_val("R11", "flags in reset", {58'h0, flags}, 58'h0);
    flag_we = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_val("R11", "flags after release", {58'h0, flags}, 58'h0);
    // Named corner: 7 - 4 = 3 (R1).
    run_case(1, 32'd7, 32'd4);
    // Compare on equal operands: no write-back, eq and zero set (R6).
    run_case(3, 32'h8000_0000, 32'h8000_0000);
    expect_val("R6", "cmp eq flags", {58'h0, flags}, {58'h0, 6'b000101});
    // Signed vs unsigned: -1 < 1 signed, borrow clear (R7, R8).
    run_case(3, 32'hFFFF_FFFF, 32'h0000_0001);
    expect_val("R7", "signed lt", {58'h0, flags}, {58'h0, 6'b011000});
    // Full sweep.
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++) begin
          if (op > 16 && (i > 1 || j > 1)) continue;
          run_case(op, pat[i], pat[j]);
        end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule